// File: doc/BRIEF.md
# Grouped Clock Stop Controller

This block sits between a set of free-running clock groups and the pins that carry them to the rest of a board. It gates each group in response to three active-low requests: a processor-clock stop, a peripheral-bus stop and a global power-down. A stopped output always parks at logic low. When a request is released the output restarts on a clean edge, without a runt high pulse.

The requests act on different subsets. The processor stop gates the host group and the 66 MHz group. The peripheral stop gates the bus clock group but not the separate free-running bus clock. The half-host, interrupt-controller, reference and 48 MHz clocks follow only power-down, and power-down overrides everything. Each output bit has its own gating lane. The lane brings the combined request across on the falling edge of its own clock with two flops. It then updates a two-state machine, GS_RUN and GS_PARK. Transition T_STOP goes from GS_RUN to GS_PARK when the synchronized request reads stop. Transition T_START goes from GS_PARK to GS_RUN when it reads run. The machine drives a latch that is open only while the clock is low, and the latch output ANDs the clock.

Top module: `clkstop_ctrl`

## Requirements
- R1: When `pwrdn_n_i` is low, every output is low from no later than the fourth rising edge of its own clock after `pwrdn_n_i` fell, whatever `cpu_stop_n_i` and `pci_stop_n_i` are.
- R2: When `pci_stop_n_i` is low and `pwrdn_n_i` is high, every bit of `pci_o` is low from no later than the fourth rising edge of its clock.
- R3: `pcif_o` keeps toggling while `pci_stop_n_i` is low, as long as `pwrdn_n_i` is high.
- R4: When `cpu_stop_n_i` is low and `pwrdn_n_i` is high, every bit of `host_o` and `g66_o` is low from no later than the fourth rising edge of its own clock.
- R5: `half_o`, `apic_o`, `ref_o` and `usb_o` keep toggling under any level of `cpu_stop_n_i` and `pci_stop_n_i` while `pwrdn_n_i` is high.
- R6: All three controls are active low. With all three high, every output follows its input clock.
- R7: A stopped output is held at logic low. No output ever shows a high pulse shorter than half its input clock period, on assertion or on release of a request.
- R8: After a request is released, the affected outputs resume toggling within four periods of their own clock, and the first pulse has full width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_i | input | N_HOST | Host clock group |
| g66_i | input | N_G66 | 66 MHz clock group |
| pci_i | input | N_PCI | Bus clock group |
| pcif_i | input | 1 | Free-running bus clock |
| half_i | input | N_HALF | Half-host clock group |
| apic_i | input | N_APIC | Interrupt-controller clock group |
| ref_i | input | N_REF | Reference clock group |
| usb_i | input | 1 | 48 MHz clock |
| cpu_stop_n_i | input | 1 | Active-low stop for host and 66 MHz groups |
| pci_stop_n_i | input | 1 | Active-low stop for bus clock group |
| pwrdn_n_i | input | 1 | Active-low power-down for all outputs |
| host_o | output | N_HOST | Gated host clocks |
| g66_o | output | N_G66 | Gated 66 MHz clocks |
| pci_o | output | N_PCI | Gated bus clocks |
| pcif_o | output | 1 | Gated free-running bus clock |
| half_o | output | N_HALF | Gated half-host clocks |
| apic_o | output | N_APIC | Gated interrupt-controller clocks |
| ref_o | output | N_REF | Gated reference clocks |
| usb_o | output | 1 | Gated 48 MHz clock |

## Verification
The assertions check on every cycle that a rising edge never appears on a gated output once its request has been held for three falling edges of that output's clock. They cover the host, 66 MHz and bus groups under their stops, and the reference and free-running bus clocks under power-down. Which groups keep running under each control combination can only be shown by the bench's scenarios. The same holds for restart after release and for the width of every high pulse. The bench sweeps all eight control combinations and measures pulse widths on every group throughout.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

    typedef enum logic {
        GS_PARK = 1'b0,
        GS_RUN  = 1'b1
    } gate_state_e;

endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic clr_n_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // falling-edge capture so the result is stable across the low phase
    always_ff @(negedge clk_i or negedge clr_n_i) begin
        if (!clr_n_i) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate
    import clkstop_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic pwrdn_n_i,
    input  logic stop_n_i,
    output logic clk_o
);
    logic        run_req;
    logic        run_sync;
    gate_state_e state_q;
    gate_state_e state_d;
    logic        en_d;
    logic        en_lat;

    assign run_req = pwrdn_n_i & stop_n_i;

    clkstop_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .clr_n_i (pwrdn_n_i),
        .d_i     (run_req),
        .q_o     (run_sync)
    );

    // state register: power-down parks at once, the latch still waits for a low phase
    always_ff @(negedge clk_i or negedge pwrdn_n_i) begin
        if (!pwrdn_n_i) begin
            state_q <= GS_PARK;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_RUN:  if (!run_sync) state_d = GS_PARK; // T_STOP
            GS_PARK: if (run_sync)  state_d = GS_RUN;  // T_START
            default: state_d = GS_PARK;
        endcase
    end

    // output process
    always_comb begin
        en_d = (state_q == GS_RUN);
    end

    // enable may change only while the clock is low
    always_latch begin
        if (!clk_i) begin
            en_lat = en_d;
        end
    end

    assign clk_o = clk_i & en_lat;
endmodule

// File: rtl/clkstop_group.sv
module clkstop_group #(
    parameter int WIDTH       = 4,
    parameter bit USE_STOP    = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic [WIDTH-1:0] clk_i,
    input  logic             pwrdn_n_i,
    input  logic             stop_n_i,
    output logic [WIDTH-1:0] clk_o
);
    logic stop_eff_n;

    generate
        if (USE_STOP) begin : g_stoppable
            assign stop_eff_n = stop_n_i;
        end else begin : g_free
            logic unused_stop;
            assign unused_stop = stop_n_i;
            assign stop_eff_n  = 1'b1;
        end
    endgenerate

    for (genvar i = 0; i < WIDTH; i++) begin : g_lane
        clkstop_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
            .clk_i     (clk_i[i]),
            .pwrdn_n_i (pwrdn_n_i),
            .stop_n_i  (stop_eff_n),
            .clk_o     (clk_o[i])
        );
    end
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl #(
    parameter int N_HOST      = 4,
    parameter int N_G66       = 4,
    parameter int N_PCI       = 7,
    parameter int N_HALF      = 2,
    parameter int N_APIC      = 3,
    parameter int N_REF       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic [N_HOST-1:0] host_i,
    input  logic [N_G66-1:0]  g66_i,
    input  logic [N_PCI-1:0]  pci_i,
    input  logic              pcif_i,
    input  logic [N_HALF-1:0] half_i,
    input  logic [N_APIC-1:0] apic_i,
    input  logic [N_REF-1:0]  ref_i,
    input  logic              usb_i,
    input  logic              cpu_stop_n_i,
    input  logic              pci_stop_n_i,
    input  logic              pwrdn_n_i,
    output logic [N_HOST-1:0] host_o,
    output logic [N_G66-1:0]  g66_o,
    output logic [N_PCI-1:0]  pci_o,
    output logic              pcif_o,
    output logic [N_HALF-1:0] half_o,
    output logic [N_APIC-1:0] apic_o,
    output logic [N_REF-1:0]  ref_o,
    output logic              usb_o
);
    localparam logic ALWAYS_RUN = 1'b1;

    clkstop_group #(.WIDTH(N_HOST), .USE_STOP(1'b1), .SYNC_STAGES(SYNC_STAGES)) u_host (
        .clk_i(host_i), .pwrdn_n_i(pwrdn_n_i), .stop_n_i(cpu_stop_n_i), .clk_o(host_o));

    clkstop_group #(.WIDTH(N_G66), .USE_STOP(1'b1), .SYNC_STAGES(SYNC_STAGES)) u_g66 (
        .clk_i(g66_i), .pwrdn_n_i(pwrdn_n_i), .stop_n_i(cpu_stop_n_i), .clk_o(g66_o));

    clkstop_group #(.WIDTH(N_PCI), .USE_STOP(1'b1), .SYNC_STAGES(SYNC_STAGES)) u_pci (
        .clk_i(pci_i), .pwrdn_n_i(pwrdn_n_i), .stop_n_i(pci_stop_n_i), .clk_o(pci_o));

    clkstop_group #(.WIDTH(1), .USE_STOP(1'b0), .SYNC_STAGES(SYNC_STAGES)) u_pcif (
        .clk_i(pcif_i), .pwrdn_n_i(pwrdn_n_i), .stop_n_i(pci_stop_n_i), .clk_o(pcif_o));

    clkstop_group #(.WIDTH(N_HALF), .USE_STOP(1'b0), .SYNC_STAGES(SYNC_STAGES)) u_half (
        .clk_i(half_i), .pwrdn_n_i(pwrdn_n_i), .stop_n_i(ALWAYS_RUN), .clk_o(half_o));

    clkstop_group #(.WIDTH(N_APIC), .USE_STOP(1'b0), .SYNC_STAGES(SYNC_STAGES)) u_apic (
        .clk_i(apic_i), .pwrdn_n_i(pwrdn_n_i), .stop_n_i(ALWAYS_RUN), .clk_o(apic_o));

    clkstop_group #(.WIDTH(N_REF), .USE_STOP(1'b0), .SYNC_STAGES(SYNC_STAGES)) u_ref (
        .clk_i(ref_i), .pwrdn_n_i(pwrdn_n_i), .stop_n_i(ALWAYS_RUN), .clk_o(ref_o));

    clkstop_group #(.WIDTH(1), .USE_STOP(1'b0), .SYNC_STAGES(SYNC_STAGES)) u_usb (
        .clk_i(usb_i), .pwrdn_n_i(pwrdn_n_i), .stop_n_i(ALWAYS_RUN), .clk_o(usb_o));
endmodule

// File: rtl/clkstop_chk.sv
module clkstop_chk #(
    parameter int N_HOST = 4,
    parameter int N_G66  = 4,
    parameter int N_PCI  = 7,
    parameter int N_REF  = 2
) (
    input logic [N_HOST-1:0] host_i,
    input logic [N_G66-1:0]  g66_i,
    input logic [N_PCI-1:0]  pci_i,
    input logic              pcif_i,
    input logic [N_REF-1:0]  ref_i,
    input logic              cpu_stop_n_i,
    input logic              pci_stop_n_i,
    input logic              pwrdn_n_i,
    input logic [N_HOST-1:0] host_o,
    input logic [N_G66-1:0]  g66_o,
    input logic [N_PCI-1:0]  pci_o,
    input logic              pcif_o,
    input logic [N_REF-1:0]  ref_o
);
    logic host_run, pci_run;
    logic [1:0] host_cnt, g66_cnt, pci_cnt, pcif_cnt, ref_cnt;

    assign host_run = cpu_stop_n_i & pwrdn_n_i;
    assign pci_run  = pci_stop_n_i & pwrdn_n_i;

    // falling edges seen while a request holds, saturating at 3
    always_ff @(negedge host_i[0] or posedge host_run) begin
        if (host_run) host_cnt <= '0;
        else if (host_cnt != 2'd3) host_cnt <= host_cnt + 2'd1;
    end
    always_ff @(negedge g66_i[0] or posedge host_run) begin
        if (host_run) g66_cnt <= '0;
        else if (g66_cnt != 2'd3) g66_cnt <= g66_cnt + 2'd1;
    end
    always_ff @(negedge pci_i[0] or posedge pci_run) begin
        if (pci_run) pci_cnt <= '0;
        else if (pci_cnt != 2'd3) pci_cnt <= pci_cnt + 2'd1;
    end
    always_ff @(negedge pcif_i or posedge pwrdn_n_i) begin
        if (pwrdn_n_i) pcif_cnt <= '0;
        else if (pcif_cnt != 2'd3) pcif_cnt <= pcif_cnt + 2'd1;
    end
    always_ff @(negedge ref_i[0] or posedge pwrdn_n_i) begin
        if (pwrdn_n_i) ref_cnt <= '0;
        else if (ref_cnt != 2'd3) ref_cnt <= ref_cnt + 2'd1;
    end

    always @(posedge (|host_o)) begin
        // R4
        host_stop_settle_chk: assert (host_run || host_cnt != 2'd3)
            else $error("host output rose after stop settled");
    end
    always @(posedge (|g66_o)) begin
        // R4
        g66_stop_settle_chk: assert (host_run || g66_cnt != 2'd3)
            else $error("66 MHz output rose after stop settled");
    end
    always @(posedge (|pci_o)) begin
        // R2
        pci_stop_settle_chk: assert (pci_run || pci_cnt != 2'd3)
            else $error("bus output rose after stop settled");
    end
    always @(posedge pcif_o) begin
        // R1
        pcif_pwrdn_settle_chk: assert (pwrdn_n_i || pcif_cnt != 2'd3)
            else $error("free bus clock rose in power-down");
    end
    always @(posedge (|ref_o)) begin
        // R1
        ref_pwrdn_settle_chk: assert (pwrdn_n_i || ref_cnt != 2'd3)
            else $error("reference output rose in power-down");
    end
endmodule

bind clkstop_ctrl clkstop_chk #(
    .N_HOST(N_HOST), .N_G66(N_G66), .N_PCI(N_PCI), .N_REF(N_REF)
) u_chk (.*);

// File: tb/clkstop_ctrl_tb.sv
`timescale 1ns/10ps
module clkstop_ctrl_tb;
    localparam int NG = 8;

    logic [3:0] host_i = '0;
    logic [3:0] g66_i  = '0;
    logic [6:0] pci_i  = '0;
    logic       pcif_i = 1'b0;
    logic [1:0] half_i = '0;
    logic [2:0] apic_i = '0;
    logic [1:0] ref_i  = '0;
    logic       usb_i  = 1'b0;
    logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pwrdn_n = 1'b1;
    logic [3:0] host_o, g66_o;
    logic [6:0] pci_o;
    logic       pcif_o, usb_o;
    logic [1:0] half_o, ref_o;
    logic [2:0] apic_o;

    int checks = 0, fails = 0, short_cnt = 0;
    int any_cnt [NG];
    int all_cnt [NG];
    bit done = 0;

    always #5      host_i = ~host_i;      // 100 MHz host
    always #7.5    g66_i  = ~g66_i;
    always #15     pci_i  = ~pci_i;
    always #15.5   pcif_i = ~pcif_i;
    always #10     half_i = ~half_i;
    always #30     apic_i = ~apic_i;
    always #35     ref_i  = ~ref_i;
    always #10.5   usb_i  = ~usb_i;

    clkstop_ctrl u_dut (
        .host_i(host_i), .g66_i(g66_i), .pci_i(pci_i), .pcif_i(pcif_i),
        .half_i(half_i), .apic_i(apic_i), .ref_i(ref_i), .usb_i(usb_i),
        .cpu_stop_n_i(cpu_stop_n), .pci_stop_n_i(pci_stop_n), .pwrdn_n_i(pwrdn_n),
        .host_o(host_o), .g66_o(g66_o), .pci_o(pci_o), .pcif_o(pcif_o),
        .half_o(half_o), .apic_o(apic_o), .ref_o(ref_o), .usb_o(usb_o)
    );

    logic [NG-1:0] any_v, all_v;
    assign any_v = {|host_o, |g66_o, |pci_o, pcif_o, |half_o, |apic_o, |ref_o, usb_o};
    assign all_v = {&host_o, &g66_o, &pci_o, pcif_o, &half_o, &apic_o, &ref_o, usb_o};
    localparam real HALF_P [NG] = '{5.0, 7.5, 15.0, 15.5, 10.0, 30.0, 35.0, 10.5};
    localparam string GNAME [NG] = '{"host", "g66", "pci", "pcif", "half", "apic", "ref", "usb"};

    for (genvar g = 0; g < NG; g++) begin : g_mon
        realtime t_rise = 0;
        always @(posedge any_v[NG-1-g]) begin
            any_cnt[g] = any_cnt[g] + 1;
            t_rise = $realtime;
        end
        always @(posedge all_v[NG-1-g]) all_cnt[g] = all_cnt[g] + 1;
        // R7 R8: every high pulse at full width
        always @(negedge all_v[NG-1-g]) begin
            if ($realtime - t_rise < HALF_P[g] - 0.05) begin
                short_cnt = short_cnt + 1;
                $display("FAIL R7 %s pulse width %0t expected >= %0t",
                         GNAME[g], $realtime - t_rise, HALF_P[g]);
            end
        end
    end

    task automatic clear_counts();
        for (int g = 0; g < NG; g++) begin
            any_cnt[g] = 0;
            all_cnt[g] = 0;
        end
    endtask

    task automatic check_run(input int g, input bit exp_run, input string req);
        bit ok;
        checks++;
        ok = exp_run ? (all_cnt[g] > 0) : (any_cnt[g] == 0);
        if (!ok) begin
            fails++;
            $display("FAIL %s %s running=%0d expected=%0d (cpu=%0b pci=%0b pd=%0b)",
                     req, GNAME[g], (any_cnt[g] > 0), exp_run, cpu_stop_n, pci_stop_n, pwrdn_n);
        end
    endtask

    task automatic apply(input logic [2:0] c);
        cpu_stop_n = c[2];
        pci_stop_n = c[1];
        pwrdn_n    = c[0];
        #500.3;
        clear_counts();
        #600;
        for (int g = 0; g < NG; g++) begin
            bit exp;
            string req;
            case (g)
                0, 1: begin exp = c[0] & c[2]; req = "R4"; end
                2:    begin exp = c[0] & c[1]; req = "R2"; end
                3:    begin exp = c[0];        req = "R3"; end
                default: begin exp = c[0];     req = "R5"; end
            endcase
            if (!c[0]) req = "R1";
            if (c == 3'b111) req = "R6";
            check_run(g, exp, req);
        end
    endtask

    initial begin
        clear_counts();
        #1 pwrdn_n = 1'b0;
        #300;
        // reset state: all parked
        checks++;
        if (any_v !== '0) begin
            fails++;
            $display("FAIL R1 reset outputs=%b expected=%b", any_v, {NG{1'b0}});
        end
        for (int c = 7; c >= 0; c--) apply(3'(c));
        for (int c = 0; c < 8; c++) apply(3'(c ^ (c >> 1)));
        apply(3'b111);
        // R4 stop lands within four host periods
        cpu_stop_n = 1'b0;
        #40;
        clear_counts();
        #100;
        check_run(0, 1'b0, "R4");
        // R8 restart within four host periods
        clear_counts();
        cpu_stop_n = 1'b1;
        #40;
        check_run(0, 1'b1, "R8");
        #200;
        checks++;
        if (short_cnt != 0) begin
            fails++;
            $display("FAIL R7 short pulses=%0d expected=0", short_cnt);
        end
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #150000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule